// File: doc/BRIEF.md
# Character LCD Command Sequencer

This block turns high-level display requests from a host into single 8-bit parallel bus cycles for a character LCD controller. The host presents an operation code and an argument over a valid/ready handshake. The block encodes them into register-select, read/write and data values. It drives an enable strobe with a parameterised setup time and pulse width. It then holds off the host until the panel is able to take the next operation.

The wait after each cycle can be produced in two ways, chosen per request by `poll_mode`, which is sampled when the request is accepted. In timed mode a counter runs for a per-class execution time. These times are derived from `CLK_HZ`, rounded up, and given a fixed margin. In polling mode the block issues status reads until the busy bit reads zero. It then waits for a short mandatory gap, measured from the falling strobe of that last status read. Data reads and status reads return the sampled byte to the host as a one-cycle response.

The controller FSM has the states IDLE, OP, WAIT, POLL and GAP. Its transitions are:
- IDLE to OP when a legal request is accepted.
- OP to IDLE when a status-class cycle ends.
- OP to WAIT when the cycle ends in timed mode.
- OP to POLL when the cycle ends in polling mode.
- POLL to POLL when busy is read as 1.
- POLL to GAP when busy is read as 0.
- WAIT to IDLE and GAP to IDLE when the timer finishes.

The bus-cycle FSM has the states BIDLE, SETUP, HIGH and HOLD, entered in that order.

Top module: `lcd_cmd_seq`

## Requirements
- R1: Each instruction code is encoded on `lcd_db_out` with `lcd_rs`=0 and `lcd_rw`=0, and don't-care bits are driven as 0. The codes are:
  - 0 (clear) gives 0x01.
  - 1 (home) gives 0x02.
  - 2 (entry) gives 0x04|arg[1:0].
  - 3 (display) gives 0x08|arg[2:0].
  - 4 (shift) gives 0x10|(arg[1:0]<<2).
  - 5 (function) gives 0x20|(arg[2:0]<<2).
  - 6 (CG address) gives 0x40|arg[5:0].
  - 7 (DD address) gives 0x80|arg[6:0].
- R2: Code 8 (write) drives rs=1, rw=0, `lcd_db_oe`=1 and data=arg. Code 9 (read) drives rs=1, rw=1 and `lcd_db_oe`=0. The read returns the byte on `lcd_db_in`, sampled in the last strobe-high cycle, as a one-cycle `rsp_valid` with `rsp_data`.
- R3: Code 10 (status) drives rs=0 and rw=1. It returns `{busy, address}` as read on `lcd_db_in` through `rsp_valid`/`rsp_data`. `req_ready` returns in the first cycle after the strobe falls.
- R4: `lcd_e` stays high for exactly EHI_CYC cycles. `lcd_rs`, `lcd_rw` and `lcd_db_out` hold their values for at least SETUP_CYC cycles before the strobe rises, and stay stable while it is high.
- R5: In timed mode, codes 0 and 1 hold `req_ready` low until ceil(1.53 ms·CLK_HZ)+MARGIN_CYC cycles after the strobe falls.
- R6: In timed mode, codes 2 to 7 wait ceil(39 µs·CLK_HZ)+MARGIN_CYC cycles after the strobe falls.
- R7: In timed mode, codes 8 and 9 wait ceil(43 µs·CLK_HZ)+MARGIN_CYC cycles after the strobe falls.
- R8: In polling mode, codes 0 to 9 are followed by status reads (rs=0, rw=1) for as long as bit 7 reads 1. `req_ready` returns ceil(CLK_HZ/540000)+MARGIN_CYC cycles after the strobe of the status read that returned 0. `poll_mode` is sampled only at acceptance.
- R9: `req_ready` falls in the cycle after a legal request is accepted and stays low until the wait ends. A request held while ready is low is neither lost nor issued early, and each accepted request produces exactly one operation cycle.
- R10: Codes 11 to 15 are accepted without any bus cycle, and `req_ready` stays high.
- R11: After reset, `req_ready`=1, `lcd_e`=0, `lcd_db_oe`=0 and `rsp_valid`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Block can accept a request |
| req_op | input | 4 | Operation code |
| req_arg | input | 8 | Operation argument |
| poll_mode | input | 1 | 1: busy-bit polling, 0: timed wait |
| rsp_valid | output | 1 | Response byte valid (one cycle) |
| rsp_data | output | 8 | Read data or busy/address byte |
| lcd_rs | output | 1 | Register select |
| lcd_rw | output | 1 | Read (1) / write (0) |
| lcd_e | output | 1 | Enable strobe |
| lcd_db_out | output | 8 | Data bus drive value |
| lcd_db_oe | output | 1 | Data bus output enable |
| lcd_db_in | input | 8 | Data bus sampled value |

## Verification
Two functions can coincide at the end of a wait. A new request that has been held pending, and the timer's final count, fall on the same edge. The bench provokes this by presenting the next request immediately after the previous one is accepted. It judges that the ready window has exactly the expected length, that no extra strobe appears during the wait, and that the pending request is then accepted and encoded correctly. The read response pulse and the return of ready also coincide for status reads. Both are checked in that same cycle.

// File: rtl/lcd_seq_pkg.sv
package lcd_seq_pkg;

    typedef enum logic [3:0] {
        OP_CLEAR   = 4'd0,
        OP_HOME    = 4'd1,
        OP_ENTRY   = 4'd2,
        OP_DISPLAY = 4'd3,
        OP_SHIFT   = 4'd4,
        OP_FUNC    = 4'd5,
        OP_CGADDR  = 4'd6,
        OP_DDADDR  = 4'd7,
        OP_WRITE   = 4'd8,
        OP_READ    = 4'd9,
        OP_STATUS  = 4'd10
    } lcd_op_e;

    typedef enum logic [1:0] {
        WT_NONE,
        WT_SHORT,
        WT_LONG,
        WT_DATA
    } wait_cls_e;

    typedef struct packed {
        logic      rs;
        logic      rw;
        logic [7:0] db;
        wait_cls_e cls;
        logic      rd_rsp;
    } bus_word_t;

endpackage

// File: rtl/lcd_req_encode.sv
module lcd_req_encode
    import lcd_seq_pkg::*;
(
    input  logic [3:0] op,
    input  logic [7:0] arg,
    output bus_word_t  word,
    output logic       legal
);

    always_comb begin
        word  = '0;
        legal = 1'b1;
        case (op)
            OP_CLEAR: begin
                word.db  = 8'h01;
                word.cls = WT_LONG;
            end
            OP_HOME: begin
                word.db  = 8'h02;
                word.cls = WT_LONG;
            end
            OP_ENTRY: begin
                word.db  = {6'b000001, arg[1:0]};
                word.cls = WT_SHORT;
            end
            OP_DISPLAY: begin
                word.db  = {5'b00001, arg[2:0]};
                word.cls = WT_SHORT;
            end
            OP_SHIFT: begin
                word.db  = {4'b0001, arg[1:0], 2'b00};
                word.cls = WT_SHORT;
            end
            OP_FUNC: begin
                word.db  = {3'b001, arg[2:0], 2'b00};
                word.cls = WT_SHORT;
            end
            OP_CGADDR: begin
                word.db  = {2'b01, arg[5:0]};
                word.cls = WT_SHORT;
            end
            OP_DDADDR: begin
                word.db  = {1'b1, arg[6:0]};
                word.cls = WT_SHORT;
            end
            OP_WRITE: begin
                word.rs  = 1'b1;
                word.db  = arg;
                word.cls = WT_DATA;
            end
            OP_READ: begin
                word.rs     = 1'b1;
                word.rw     = 1'b1;
                word.cls    = WT_DATA;
                word.rd_rsp = 1'b1;
            end
            OP_STATUS: begin
                word.rw     = 1'b1;
                word.cls    = WT_NONE;
                word.rd_rsp = 1'b1;
            end
            default: legal = 1'b0;
        endcase
    end

endmodule

// File: rtl/lcd_delay_timer.sv
module lcd_delay_timer #(
    parameter int CW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          last
);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign last = (cnt == CW'(1));

endmodule

// File: rtl/lcd_bus_cycle.sv
module lcd_bus_cycle #(
    parameter int SETUP_CYC = 2,
    parameter int EHI_CYC   = 12
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       rs_i,
    input  logic       rw_i,
    input  logic [7:0] wd_i,
    input  logic [7:0] db_in,
    output logic       lcd_rs,
    output logic       lcd_rw,
    output logic       lcd_e,
    output logic [7:0] lcd_db_out,
    output logic       lcd_db_oe,
    output logic       done,
    output logic [7:0] rdata
);

    localparam int MAXC = (SETUP_CYC > EHI_CYC) ? SETUP_CYC : EHI_CYC;
    localparam int CW   = $clog2(MAXC + 1);

    typedef enum logic [1:0] {BIDLE, SETUP, HIGH, HOLD} bstate_e;

    bstate_e       state, nxt;
    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= BIDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            BIDLE: if (start)      nxt = SETUP;
            SETUP: if (cnt == '0)  nxt = HIGH;
            HIGH:  if (cnt == '0)  nxt = HOLD;
            HOLD:                  nxt = BIDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt        <= '0;
            lcd_rs     <= 1'b0;
            lcd_rw     <= 1'b0;
            lcd_e      <= 1'b0;
            lcd_db_out <= '0;
            lcd_db_oe  <= 1'b0;
            rdata      <= '0;
        end else begin
            unique case (state)
                BIDLE: if (start) begin
                    lcd_rs     <= rs_i;
                    lcd_rw     <= rw_i;
                    lcd_db_out <= rw_i ? 8'h00 : wd_i;
                    lcd_db_oe  <= ~rw_i;
                    cnt        <= CW'(SETUP_CYC - 1);
                end
                SETUP: if (cnt == '0) begin
                    lcd_e <= 1'b1;
                    cnt   <= CW'(EHI_CYC - 1);
                end else begin
                    cnt <= cnt - 1'b1;
                end
                HIGH: if (cnt == '0) begin
                    lcd_e <= 1'b0;
                    rdata <= db_in;
                end else begin
                    cnt <= cnt - 1'b1;
                end
                HOLD: lcd_db_oe <= 1'b0;
            endcase
        end
    end

    assign done = (state == HOLD);

endmodule

// File: rtl/lcd_cmd_seq.sv
module lcd_cmd_seq
    import lcd_seq_pkg::*;
#(
    parameter int CLK_HZ     = 50_000_000,
    parameter int SETUP_CYC  = 2,
    parameter int EHI_CYC    = 12,
    parameter int MARGIN_CYC = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_valid,
    output logic       req_ready,
    input  logic [3:0] req_op,
    input  logic [7:0] req_arg,
    input  logic       poll_mode,
    output logic       rsp_valid,
    output logic [7:0] rsp_data,
    output logic       lcd_rs,
    output logic       lcd_rw,
    output logic       lcd_e,
    output logic [7:0] lcd_db_out,
    output logic       lcd_db_oe,
    input  logic [7:0] lcd_db_in
);

    localparam longint unsigned HZ      = longint'(CLK_HZ);
    localparam longint unsigned N_LONG  = (64'd1530 * HZ + 64'd999_999) / 64'd1_000_000 + MARGIN_CYC;
    localparam longint unsigned N_SHORT = (64'd39 * HZ + 64'd999_999) / 64'd1_000_000 + MARGIN_CYC;
    localparam longint unsigned N_DATA  = (64'd43 * HZ + 64'd999_999) / 64'd1_000_000 + MARGIN_CYC;
    localparam longint unsigned N_GAP   = (HZ + 64'd539_999) / 64'd540_000 + MARGIN_CYC;
    localparam int              TCW     = $clog2(N_LONG + 1);

    typedef enum logic [2:0] {S_IDLE, S_OP, S_WAIT, S_POLL, S_GAP} state_e;

    state_e         state, nxt;
    bus_word_t      enc_word, cmd;
    logic           enc_legal;
    logic           poll_q;
    logic           start_q;
    logic           phy_done;
    logic [7:0]     phy_rdata;
    logic           tmr_load, tmr_last;
    logic [TCW-1:0] tmr_val;
    logic           accept;

    lcd_req_encode u_enc (
        .op    (req_op),
        .arg   (req_arg),
        .word  (enc_word),
        .legal (enc_legal)
    );

    lcd_bus_cycle #(
        .SETUP_CYC (SETUP_CYC),
        .EHI_CYC   (EHI_CYC)
    ) u_bus (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start_q),
        .rs_i       ((state == S_POLL) ? 1'b0 : cmd.rs),
        .rw_i       ((state == S_POLL) ? 1'b1 : cmd.rw),
        .wd_i       (cmd.db),
        .db_in      (lcd_db_in),
        .lcd_rs     (lcd_rs),
        .lcd_rw     (lcd_rw),
        .lcd_e      (lcd_e),
        .lcd_db_out (lcd_db_out),
        .lcd_db_oe  (lcd_db_oe),
        .done       (phy_done),
        .rdata      (phy_rdata)
    );

    lcd_delay_timer #(.CW(TCW)) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .last     (tmr_last)
    );

    assign req_ready = (state == S_IDLE);
    assign accept    = req_ready && req_valid && enc_legal;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE: if (accept) nxt = S_OP;
            S_OP: if (phy_done) begin
                if (cmd.cls == WT_NONE) nxt = S_IDLE;
                else if (poll_q)        nxt = S_POLL;
                else                    nxt = S_WAIT;
            end
            S_WAIT: if (tmr_last) nxt = S_IDLE;
            S_POLL: if (phy_done && !phy_rdata[7]) nxt = S_GAP;
            S_GAP:  if (tmr_last) nxt = S_IDLE;
            default: nxt = S_IDLE;
        endcase
    end

    always_comb begin
        tmr_load = 1'b0;
        tmr_val  = '0;
        if (state == S_OP && phy_done && !poll_q && cmd.cls != WT_NONE) begin
            tmr_load = 1'b1;
            unique case (cmd.cls)
                WT_LONG:  tmr_val = TCW'(N_LONG - 1);
                WT_DATA:  tmr_val = TCW'(N_DATA - 1);
                default:  tmr_val = TCW'(N_SHORT - 1);
            endcase
        end else if (state == S_POLL && phy_done && !phy_rdata[7]) begin
            tmr_load = 1'b1;
            tmr_val  = TCW'(N_GAP - 1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd       <= '0;
            poll_q    <= 1'b0;
            start_q   <= 1'b0;
            rsp_valid <= 1'b0;
            rsp_data  <= '0;
        end else begin
            start_q   <= 1'b0;
            rsp_valid <= 1'b0;
            unique case (state)
                S_IDLE: if (accept) begin
                    cmd     <= enc_word;
                    poll_q  <= poll_mode;
                    start_q <= 1'b1;
                end
                S_OP: if (phy_done) begin
                    rsp_valid <= cmd.rd_rsp;
                    rsp_data  <= phy_rdata;
                    if (cmd.cls != WT_NONE && poll_q) start_q <= 1'b1;
                end
                S_POLL: if (phy_done && phy_rdata[7]) start_q <= 1'b1;
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/lcd_cmd_seq_chk.sv
module lcd_cmd_seq_chk #(
    parameter int EHI_CYC = 12
) (
    input logic       clk,
    input logic       rst_n,
    input logic       req_valid,
    input logic       req_ready,
    input logic [3:0] req_op,
    input logic       rsp_valid,
    input logic       lcd_rs,
    input logic       lcd_rw,
    input logic       lcd_e,
    input logic [7:0] lcd_db_out,
    input logic       lcd_db_oe
);

    logic [15:0] e_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     e_cnt <= '0;
        else if (lcd_e) e_cnt <= e_cnt + 1'b1;
        else            e_cnt <= '0;
    end

    assert_e_width_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(lcd_e) |-> (e_cnt == 16'(EHI_CYC)));

    assert_bus_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (lcd_e && $past(lcd_e)) |-> ($stable(lcd_rs) && $stable(lcd_rw) && $stable(lcd_db_out)));

    assert_read_release_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (lcd_e && lcd_rw) |-> !lcd_db_oe);

    assert_no_strobe_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !lcd_e);

    assert_accept_drops_ready_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && (req_op <= 4'd10)) |=> !req_ready);

    assert_unused_op_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && (req_op > 4'd10)) |=> (req_ready && !lcd_e));

    assert_rsp_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

endmodule

bind lcd_cmd_seq lcd_cmd_seq_chk #(.EHI_CYC(EHI_CYC)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_op     (req_op),
    .rsp_valid  (rsp_valid),
    .lcd_rs     (lcd_rs),
    .lcd_rw     (lcd_rw),
    .lcd_e      (lcd_e),
    .lcd_db_out (lcd_db_out),
    .lcd_db_oe  (lcd_db_oe)
);

// File: tb/lcd_cmd_seq_bench.sv
module lcd_cmd_seq_bench;

    localparam int CLK_HZ = 2_000_000;
    localparam int SETUP  = 2;
    localparam int EHI    = 3;
    localparam int MARGIN = 3;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic       rst_n, req_valid, req_ready, poll_mode, rsp_valid;
    logic [3:0] req_op;
    logic [7:0] req_arg, rsp_data, lcd_db_out, lcd_db_in, rd_byte;
    logic       lcd_rs, lcd_rw, lcd_e, lcd_db_oe;
    logic [6:0] ac_val;
    int         busy_left;
    int         checks = 0;
    int         errors = 0;
    bit         finished = 1'b0;

    assign lcd_db_in = lcd_rs ? rd_byte : {(busy_left != 0), ac_val};

    lcd_cmd_seq #(
        .CLK_HZ(CLK_HZ), .SETUP_CYC(SETUP), .EHI_CYC(EHI), .MARGIN_CYC(MARGIN)
    ) u_lcd_cmd_seq (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_op(req_op), .req_arg(req_arg), .poll_mode(poll_mode),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data), .lcd_rs(lcd_rs), .lcd_rw(lcd_rw),
        .lcd_e(lcd_e), .lcd_db_out(lcd_db_out), .lcd_db_oe(lcd_db_oe), .lcd_db_in(lcd_db_in)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int ceil_ns(input longint ns);
        return int'((ns * CLK_HZ + 64'd999_999_999) / 64'd1_000_000_000) + MARGIN;
    endfunction

    function automatic int exp_wait(input int op, input bit poll);
        if (op == 10) return 1;
        if (poll)     return int'((longint'(CLK_HZ) + 539_999) / 540_000) + MARGIN;
        if (op <= 1)  return ceil_ns(1_530_000);
        if (op >= 8)  return ceil_ns(43_000);
        return ceil_ns(39_000);
    endfunction

    function automatic logic [9:0] exp_word(input int op, input logic [7:0] a);
        case (op)
            0: return {2'b00, 8'h01};
            1: return {2'b00, 8'h02};
            2: return {2'b00, 8'h04 | {6'b0, a[1:0]}};
            3: return {2'b00, 8'h08 | {5'b0, a[2:0]}};
            4: return {2'b00, 8'h10 | {4'b0, a[1:0], 2'b00}};
            5: return {2'b00, 8'h20 | {3'b0, a[2:0], 2'b00}};
            6: return {2'b00, 8'h40 | {2'b0, a[5:0]}};
            7: return {2'b00, 8'h80 | {1'b0, a[6:0]}};
            8: return {2'b10, a};
            9: return {2'b11, 8'h00};
            default: return {2'b01, 8'h00};
        endcase
    endfunction

    task automatic accept();
        while (!req_ready) @(negedge clk);
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic watch(input int op, input logic [7:0] a, input bit poll, input int nbusy);
        logic [9:0] w = exp_word(op, a);
        logic [9:0] prev = {lcd_rs, lcd_rw, lcd_db_out};
        logic [9:0] cur;
        logic [7:0] exp_rsp = (op == 9) ? rd_byte : {(nbusy != 0), ac_val};
        bit e_prev = 1'b0, seen_fall = 1'b0;
        int rises = 0, c = 0, ehi = 0, stable = 0, rsps = 0;
        int exp_rises = (op == 10 || !poll) ? 1 : nbusy + 2;
        bit do_poll = poll && op != 10;
        for (int it = 0; it < 20000; it++) begin
            @(negedge clk);
            cur = {lcd_rs, lcd_rw, lcd_db_out};
            stable = (cur == prev) ? stable + 1 : 1;
            if (lcd_e && !e_prev) begin
                rises++;
                if (rises == 1) begin
                    if (w[8]) chk(lcd_rs == w[9] && lcd_rw && !lcd_db_oe, "R2/R3 read encoding", {lcd_rs, lcd_rw, lcd_db_oe}, {w[9], 2'b10});
                    else if (w[9]) chk(lcd_rs && !lcd_rw && lcd_db_oe && lcd_db_out == w[7:0], "R2 write encoding", cur, w);
                    else chk(cur == w && lcd_db_oe, "R1 instruction encoding", cur, w);
                end else begin
                    chk(!lcd_rs && lcd_rw && !lcd_db_oe, "R8 poll cycle is status read", {lcd_rs, lcd_rw}, 2'b01);
                end
                chk(stable >= SETUP + 1, "R4 setup before strobe", stable, SETUP + 1);
            end
            if (lcd_e) ehi++;
            if (!lcd_e && e_prev) begin
                chk(ehi == EHI, "R4 strobe width", ehi, EHI);
                ehi = 0;
                c = 0;
                seen_fall = 1'b1;
                if (rises > 1 && busy_left > 0) busy_left--;
            end else if (seen_fall) begin
                c++;
            end
            if (rsp_valid) begin
                rsps++;
                chk(rsp_data == exp_rsp, (op == 9) ? "R2 read data" : "R3 status data", rsp_data, exp_rsp);
            end
            if (req_ready) begin
                chk(seen_fall, "R9 ready low until wait ends", 1, int'(seen_fall));
                if (op == 10) chk(c == 1, "R3 status takes no wait", c, 1);
                else if (do_poll) chk(c == exp_wait(op, 1'b1), "R8 post-flag gap", c, exp_wait(op, 1'b1));
                else if (op <= 1) chk(c == exp_wait(op, 1'b0), "R5 long wait", c, exp_wait(op, 1'b0));
                else if (op >= 8) chk(c == exp_wait(op, 1'b0), "R7 data wait", c, exp_wait(op, 1'b0));
                else chk(c == exp_wait(op, 1'b0), "R6 short wait", c, exp_wait(op, 1'b0));
                chk(rises == exp_rises, "R9 strobes per request", rises, exp_rises);
                chk(rsps == ((op >= 9) ? 1 : 0), "R2/R3 response count", rsps, (op >= 9) ? 1 : 0);
                busy_left = 0;
                return;
            end
            e_prev = lcd_e;
            prev = cur;
        end
        chk(1'b0, "R9 operation never completed", 0, 1);
    endtask

    task automatic run_op(input int op, input logic [7:0] a, input bit poll, input int nbusy);
        busy_left = nbusy;
        req_op    = 4'(op);
        req_arg   = a;
        poll_mode = poll;
        req_valid = 1'b1;
        accept();
        req_valid = 1'b0;
        watch(op, a, poll, nbusy);
    endtask

    initial begin
        #(4 * 200_000);
        if (!finished) begin
            chk(1'b0, "R9 watchdog", 0, 1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        rst_n = 1'b0; req_valid = 1'b0; req_op = '0; req_arg = '0; poll_mode = 1'b0;
        rd_byte = 8'h5A; ac_val = 7'h21; busy_left = 0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready && !lcd_e && !lcd_db_oe && !rsp_valid, "R11 reset state",
            {req_ready, lcd_e, lcd_db_oe, rsp_valid}, 4'b1000);

        // directed encodings and timed waits
        run_op(0, 8'hFF, 1'b0, 0);
        run_op(1, 8'hFF, 1'b0, 0);
        run_op(2, 8'h03, 1'b0, 0);
        run_op(3, 8'h05, 1'b0, 0);
        run_op(4, 8'hFE, 1'b0, 0);
        run_op(5, 8'h07, 1'b0, 0);
        run_op(6, 8'hFF, 1'b0, 0);
        run_op(7, 8'hFF, 1'b0, 0);
        run_op(8, 8'hA5, 1'b0, 0);
        rd_byte = 8'hC3;
        run_op(9, 8'h00, 1'b0, 0);
        ac_val = 7'h4F;
        run_op(10, 8'h00, 1'b0, 1);
        run_op(10, 8'h00, 1'b1, 0);

        // polling mode
        run_op(0, 8'h00, 1'b1, 3);
        run_op(8, 8'h3C, 1'b1, 0);
        run_op(9, 8'h00, 1'b1, 2);

        // mode change after acceptance is ignored
        busy_left = 0; req_op = 4'd3; req_arg = 8'h04; poll_mode = 1'b0; req_valid = 1'b1;
        accept();
        req_valid = 1'b0; poll_mode = 1'b1;
        watch(3, 8'h04, 1'b0, 0);

        // request held pending while busy, issued when the wait ends
        req_op = 4'd2; req_arg = 8'h01; poll_mode = 1'b0; req_valid = 1'b1;
        accept();
        req_op = 4'd8; req_arg = 8'h99;
        watch(2, 8'h01, 1'b0, 0);
        accept();
        req_valid = 1'b0;
        watch(8, 8'h99, 1'b0, 0);

        // unused codes
        for (int k = 11; k < 16; k++) begin
            req_op = 4'(k); req_valid = 1'b1;
            accept();
            req_valid = 1'b0;
            for (int j = 0; j < 3; j++) begin
                chk(req_ready && !lcd_e, "R10 unused code ignored", {req_ready, lcd_e}, 2'b10);
                @(negedge clk);
            end
        end

        // random mix
        for (int n = 0; n < 40; n++) begin
            int op = int'($urandom_range(10, 0));
            bit pm = 1'($urandom_range(1, 0));
            if (op <= 1 && !pm && $urandom_range(3, 0) != 0) op = 2 + int'($urandom_range(8, 0));
            rd_byte = 8'($urandom);
            ac_val  = 7'($urandom);
            run_op(op, 8'($urandom), pm, int'($urandom_range(3, 0)));
        end

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule